// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the 32-bit register face of a simple serial port. A host reaches it over a word-addressed bus with one-cycle read and write strobes. Read data is combinational and valid in the cycle of the strobe. The block sends each byte written to the data-out word as a one-cycle pulse on a byte-wide transmit stream. It captures bytes from a byte-wide receive stream, and it throttles the sender with a ready signal. Transmit and receive events raise bits in a raw interrupt word. A mask selects which of those bits drive a single level-sensitive interrupt line, and an acknowledge write clears them.

Baud timing and bit shifting are left to logic outside this block. From the register side, the transmitter is therefore always idle and ready.

The transmit acknowledge follows a small state machine with two states.

- In `TX_IDLE`, nothing sent is awaiting acknowledgement. A data-out write takes transition `T_SEND` to `TX_PENDING`.
- In `TX_PENDING`, a further data-out write takes `T_RESEND` and stays in `TX_PENDING`. An acknowledge with bit 0 set takes `T_ACK_HOLD` back to `TX_IDLE`. That first acknowledge re-raises the transmit interrupt instead of clearing it.
- In `TX_IDLE`, an acknowledge with bit 0 set clears the transmit interrupt normally.

Top module: `sport_regs`

Word indices used below are byte offset divided by 4:

| Byte offset | Word | Role |
|---|---|---|
| 0x00 | 0 | transmit control |
| 0x04 | 1 | transmit DMA enable |
| 0x08 | 2 | receive control |
| 0x1C | 7 | data out |
| 0x20 | 8 | status, clear-on-read |
| 0x24 | 9 | status, peek |
| 0x2C | 11 | interrupt mask |
| 0x30 | 12 | acknowledge |
| 0x34 | 13 | raw interrupt |
| 0x38 | 14 | masked interrupt |

The window is words 0 to 14.

## Requirements
- R1: After reset, the status word reads 0x0140_0000 (bit 24 transmitter-ready and bit 22 transmitter-idle set, bit 16 data-available clear, bits [7:0] zero). The raw interrupt word reads 0, `irq` is 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: Words 0 to 7, 10 and 11 are plain 32-bit storage. Each reads back exactly the last value written to it.
- R3: A write to word 7 puts its low byte on `tx_data` with `tx_valid` high for exactly the one cycle after the write. The same write sets raw interrupt bit 0.
- R4: An accepted receive byte has three effects. It replaces status bits [7:0], it sets status bit 16, and it sets raw interrupt bit 3.
- R5: A read of word 8 returns the status word and then clears bit 16. A read of word 9 returns the same word and changes nothing.
- R6: A write to word 12 clears every raw interrupt bit whose data bit is 1. Word 12 always reads 0.
- R7: While a transmit is pending, the first acknowledge with bit 0 set leaves raw bit 0 at 1 and ends the pending state. The next such acknowledge clears raw bit 0.
- R8: Word 14 reads raw AND mask (word 11). `irq` is 1 exactly when that value is non-zero.
- R9: `rx_ready` equals receive-control (word 2) bit 0 OR NOT raw bit 3. A byte offered while `rx_ready` is 0 is dropped, and status and raw are unchanged.
- R10: Reads at word indices 15 and above return 0, and writes there are ignored. Writes to words 8, 9, 13 and 14 change nothing.
- R11: In a cycle where a receive is accepted together with a register access, two ordering rules apply. An acknowledge in that cycle does not clear the new raw bit 3. A clear-on-read in that cycle does not clear the new data-available bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| tx_valid | output | 1 | Transmit byte valid pulse |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receiver can accept a byte |
| irq | output | 1 | Level interrupt |

## Verification
Each case can be told apart at the ports within one or two cycles:

- **Stuck or missed pending state.** The double acknowledge then collapses to a single one, so `irq` and raw bit 0 drop after the first acknowledge instead of the second.
- **Lost data-available clear, or a clear on the peek alias.** Bit 16 reads wrong on the very next status read.
- **Wrong receive-capture state.** It shows directly in `rx_ready`, because that output depends on raw bit 3.
- **Wrong same-cycle ordering.** Raw bit 3 or bit 16 reads 0 straight after a combined cycle.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int WORD_W     = 32;
    localparam int WIN_WORDS  = 15;

    localparam int IDX_TXCTL     = 0;
    localparam int IDX_DMAEN     = 1;
    localparam int IDX_RXCTL     = 2;
    localparam int IDX_DOUT      = 7;
    localparam int IDX_STAT_CLR  = 8;
    localparam int IDX_STAT_PEEK = 9;
    localparam int IDX_MASK      = 11;
    localparam int IDX_ACK       = 12;
    localparam int IDX_RAW       = 13;
    localparam int IDX_MASKED    = 14;

    localparam int BIT_DAV    = 16;
    localparam int BIT_TXIDLE = 22;
    localparam int BIT_TXRDY  = 24;

    localparam int IRQ_TX = 0;
    localparam int IRQ_RX = 3;

    typedef enum logic [0:0] {
        TX_IDLE    = 1'b0,
        TX_PENDING = 1'b1
    } tx_state_e;

    function automatic logic is_plain(input int idx);
        return (idx < WIN_WORDS) &&
               (idx != IDX_STAT_CLR) && (idx != IDX_STAT_PEEK) &&
               (idx != IDX_ACK) && (idx != IDX_RAW) && (idx != IDX_MASKED);
    endfunction

endpackage

// File: rtl/sport_txfsm.sv
module sport_txfsm
    import sport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dout_we,
    input  logic [7:0] dout_byte,
    input  logic       ack_we,
    input  logic       ack_bit0,
    output logic       hold_tx,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    tx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_SEND, T_RESEND, T_ACK_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (dout_we) state_d = TX_PENDING;
            end
            TX_PENDING: begin
                if (dout_we)                 state_d = TX_PENDING;
                else if (ack_we && ack_bit0) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hold_tx = (state_q == TX_PENDING) && ack_we && ack_bit0 && !dout_we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= dout_we;
            if (dout_we) tx_data <= dout_byte;
        end
    end

    assert_tx_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_we |=> (tx_valid && tx_data == $past(dout_byte)));

    assert_tx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_we |=> !tx_valid);

    assert_pending_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_tx |=> (state_q == TX_IDLE));

endmodule

// File: rtl/sport_irq.sv
module sport_irq
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_we,
    input  logic [WORD_W-1:0] ack_data,
    input  logic              tx_set,
    input  logic              rx_set,
    input  logic              hold_tx,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] masked,
    output logic              irq
);

    logic [WORD_W-1:0] ack_eff;
    logic [WORD_W-1:0] raw_mid;
    logic [WORD_W-1:0] raw_d;

    always_comb begin
        ack_eff = ack_we ? ack_data : '0;
        if (hold_tx) ack_eff[IRQ_TX] = 1'b0;
        raw_mid = raw;
        if (tx_set || hold_tx) raw_mid[IRQ_TX] = 1'b1;
        raw_d = raw_mid & ~ack_eff;
        if (rx_set) raw_d[IRQ_RX] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= raw_d;
    end

    assign masked = raw & mask;
    assign irq    = |masked;

    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_tx |=> raw[IRQ_TX]);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !hold_tx && !rx_set && !tx_set) |=> ((raw & $past(ack_data)) == '0));

    assert_rx_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> raw[IRQ_RX]);

endmodule

// File: rtl/sport_rxcap.sv
module sport_rxcap
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_accept,
    input  logic [7:0]        rx_byte,
    input  logic              rd_clear,
    output logic [WORD_W-1:0] stat_word
);

    logic [7:0] byte_q;
    logic       dav_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            dav_q  <= 1'b0;
        end else begin
            if (rx_accept) begin
                byte_q <= rx_byte;
                dav_q  <= 1'b1;
            end else if (rd_clear) begin
                dav_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_word             = '0;
        stat_word[7:0]        = byte_q;
        stat_word[BIT_DAV]    = dav_q;
        stat_word[BIT_TXIDLE] = 1'b1;
        stat_word[BIT_TXRDY]  = 1'b1;
    end

    assert_rx_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |=> (dav_q && byte_q == $past(rx_byte)));

    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !rx_accept) |=> !dav_q);

    assert_dav_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clear && !rx_accept) |=> $stable(stat_word));

endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              irq
);

    localparam int IDX_W   = $clog2(WIN_WORDS);
    localparam int SLOTS   = 1 << IDX_W;

    logic              in_win;
    logic [IDX_W-1:0]  idx;
    logic              dout_we, ack_we, rd_clear, rx_accept, hold_tx;
    logic [WORD_W-1:0] plain_q [SLOTS];
    logic [WORD_W-1:0] raw, masked, stat_word;

    assign in_win    = (bus_addr < ADDR_W'(WIN_WORDS));
    assign idx       = bus_addr[IDX_W-1:0];
    assign dout_we   = bus_wr && in_win && (idx == IDX_W'(IDX_DOUT));
    assign ack_we    = bus_wr && in_win && (idx == IDX_W'(IDX_ACK));
    assign rd_clear  = bus_rd && in_win && (idx == IDX_W'(IDX_STAT_CLR));
    assign rx_ready  = plain_q[IDX_RXCTL][0] | ~raw[IRQ_RX];
    assign rx_accept = rx_valid && rx_ready;

    for (genvar i = 0; i < SLOTS; i++) begin : g_store
        if (is_plain(i)) begin : g_rw
            always_ff @(posedge clk) begin
                if (!rst_n)
                    plain_q[i] <= '0;
                else if (bus_wr && in_win && idx == IDX_W'(i))
                    plain_q[i] <= bus_wdata;
            end
        end else begin : g_none
            assign plain_q[i] = '0;
        end
    end

    sport_txfsm u_txfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dout_we  (dout_we),
        .dout_byte(bus_wdata[7:0]),
        .ack_we   (ack_we),
        .ack_bit0 (bus_wdata[0]),
        .hold_tx  (hold_tx),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    sport_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_we  (ack_we),
        .ack_data(bus_wdata),
        .tx_set  (dout_we),
        .rx_set  (rx_accept),
        .hold_tx (hold_tx),
        .mask    (plain_q[IDX_MASK]),
        .raw     (raw),
        .masked  (masked),
        .irq     (irq)
    );

    sport_rxcap u_rxcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_accept(rx_accept),
        .rx_byte  (rx_data),
        .rd_clear (rd_clear),
        .stat_word(stat_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            unique case (idx)
                IDX_W'(IDX_STAT_CLR),
                IDX_W'(IDX_STAT_PEEK): bus_rdata = stat_word;
                IDX_W'(IDX_ACK):       bus_rdata = '0;
                IDX_W'(IDX_RAW):       bus_rdata = raw;
                IDX_W'(IDX_MASKED):    bus_rdata = masked;
                default:               bus_rdata = plain_q[idx];
            endcase
        end
    end

    assert_rx_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !bus_wr && !bus_rd) |=>
            (stat_word == $past(stat_word) && raw == $past(raw)));

    assert_outside_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_win && !rx_accept) |=> ($stable(raw) && $stable(stat_word)));

endmodule

// File: tb/tb_sport_regs.sv
module tb_sport_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sport_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // one bus/receive cycle starting and ending at a falling edge
    task automatic cyc(input bit wr, input bit rd, input logic [7:0] boff,
                       input logic [31:0] wd, input bit rv, input logic [7:0] rd8,
                       output logic [31:0] rdv);
        bus_wr = wr; bus_rd = rd; bus_addr = boff[7:2]; bus_wdata = wd;
        rx_valid = rv; rx_data = rd8;
        #1 rdv = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rx_valid = 0;
    endtask

    task automatic wr(input logic [7:0] boff, input logic [31:0] d);
        logic [31:0] x;
        cyc(1, 0, boff, d, 0, 8'h00, x);
    endtask

    task automatic rd(input logic [7:0] boff, output logic [31:0] d);
        cyc(0, 1, boff, 32'h0, 0, 8'h00, d);
    endtask

    task automatic rx(input logic [7:0] b);
        logic [31:0] x;
        cyc(0, 0, 8'h00, 32'h0, 1, b, x);
    endtask

    task automatic idle();
        logic [31:0] x;
        cyc(0, 0, 8'h00, 32'h0, 0, 8'h00, x);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h24, v); check("R1 status", v, 32'h0140_0000);
        rd(8'h34, v); check("R1 raw", v, 32'h0);
    endtask

    task automatic t_plain();
        logic [31:0] v;
        logic [7:0] offs [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h28};
        foreach (offs[i]) begin
            wr(offs[i], 32'hA5A5_0000 | 32'(i) | 32'h10);
            rd(offs[i], v); check("R2 storage", v, 32'hA5A5_0000 | 32'(i) | 32'h10);
            wr(offs[i], 32'h0);
        end
    endtask

    task automatic t_tx();
        logic [31:0] v;
        wr(8'h1C, 32'h1234_56AB);
        check("R3 tx_valid", {31'b0, tx_valid}, 32'h1);
        check("R3 tx_data", {24'b0, tx_data}, 32'hAB);
        idle();
        check("R3 pulse ends", {31'b0, tx_valid}, 32'h0);
        rd(8'h34, v); check("R3 raw bit0", v, 32'h1);
        rd(8'h1C, v); check("R2 dout readback", v, 32'h1234_56AB);
    endtask

    task automatic t_pend_ack();
        logic [31:0] v;
        wr(8'h30, 32'h1);
        rd(8'h34, v); check("R7 first ack holds", v, 32'h1);
        wr(8'h30, 32'h1);
        rd(8'h34, v); check("R7 second ack clears", v, 32'h0);
        rd(8'h30, v); check("R6 ack reads zero", v, 32'h0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        wr(8'h2C, 32'h9);
        wr(8'h1C, 32'hC3);
        rd(8'h38, v); check("R8 masked", v, 32'h1);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'h1);
        check("R7 irq still high", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'h1);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        wr(8'h2C, 32'h8);
        wr(8'h1C, 32'h3C);
        rd(8'h34, v); check("R8 raw set", v, 32'h1);
        rd(8'h38, v); check("R8 masked off", v, 32'h0);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h30, 32'h1); wr(8'h30, 32'h1);
        rd(8'h34, v); check("R7 cleared", v, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        rx(8'h5A);
        rd(8'h24, v); check("R4 status", v, 32'h0141_005A);
        rd(8'h34, v); check("R4 raw bit3", v, 32'h8);
        check("R8 irq rx", {31'b0, irq}, 32'h1);
        check("R9 not ready", {31'b0, rx_ready}, 32'h0);
        rd(8'h24, v); check("R5 peek keeps", v, 32'h0141_005A);
        rd(8'h20, v); check("R5 clr read value", v, 32'h0141_005A);
        rd(8'h24, v); check("R5 dav cleared", v, 32'h0140_005A);
    endtask

    task automatic t_rx_blocked();
        logic [31:0] v;
        rx(8'h33);
        rd(8'h24, v); check("R9 dropped status", v, 32'h0140_005A);
        rd(8'h34, v); check("R9 dropped raw", v, 32'h8);
        wr(8'h08, 32'h1);
        check("R9 ready via ctrl", {31'b0, rx_ready}, 32'h1);
        rx(8'h77);
        rd(8'h24, v); check("R9 accepted", v, 32'h0141_0077);
        wr(8'h08, 32'h0);
        wr(8'h30, 32'h8);
        rd(8'h34, v); check("R6 ack bit3", v, 32'h0);
        check("R9 ready again", {31'b0, rx_ready}, 32'h1);
    endtask

    task automatic t_window();
        logic [31:0] v;
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h3C, v); check("R10 word15", v, 32'h0);
        rd(8'h40, v); check("R10 word16", v, 32'h0);
        wr(8'h34, 32'hFF);
        rd(8'h34, v); check("R10 raw ro", v, 32'h0);
        wr(8'h38, 32'hFF);
        rd(8'h38, v); check("R10 masked ro", v, 32'h0);
        wr(8'h20, 32'h0); wr(8'h24, 32'h0);
        rd(8'h24, v); check("R10 status ro", v, 32'h0141_0077);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        cyc(1, 0, 8'h30, 32'h8, 1, 8'h11, v);
        rd(8'h34, v); check("R11 rx beats ack", v, 32'h8);
        rd(8'h24, v); check("R11 status", v, 32'h0141_0011);
        wr(8'h08, 32'h1);
        cyc(0, 1, 8'h20, 32'h0, 1, 8'h22, v);
        check("R11 read value", v, 32'h0141_0011);
        rd(8'h24, v); check("R11 rx beats clear", v, 32'h0141_0022);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_tx();
        t_pend_ack();
        t_mask_irq();
        t_rx();
        t_rx_blocked();
        t_window();
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule